// File: doc/BRIEF.md
# Paired-Edge Mismatch Detector

This block cross-checks two redundant count inputs that are supposed to move together. Every rising edge on the primary input (A) should be accompanied by a falling edge, the leading edge of a low-going pulse, on the companion input (B). The two edges may arrive in either order, separated by no more than a programmable number of sampling-clock cycles. An edge on either input that finds no partner inside that tolerance is an error.

Errors are accumulated in a small saturating counter. Once three errors have been seen, a sticky error flag is raised and stays raised until master reset. Both count inputs are asynchronous to the sampling clock and pass through multi-flop synchronizers before edge detection. An enable input turns detection off when the companion input is not wired up.

Top module: `pulse_mismatch_detector`

## Requirements
- R1: A rising edge on A and a falling edge on B whose synchronized arrival times differ by at most `win_len` sampling-clock cycles, in either order and including the same cycle, form a good pair and add nothing to the error count.
- R2: A rising edge on A with no B falling edge inside its window adds exactly one to the error count, taking effect when the window expires `win_len`+1 cycles after the edge.
- R3: A falling edge on B with no A rising edge inside its window adds exactly one to the error count.
- R4: `err_count` is a binary count 0..3 that saturates at 3, and `err_flag` is 1 exactly when three errors have been counted.
- R5: Good pairs never clear the count or the flag; the flag, once high, stays high until reset.
- R6: A synchronous active-high `rst` clears the count to 0, drives `err_flag` low and discards any open window.
- R7: While `en` is 0 no error is counted, any open window is discarded, and the count holds its value.
- R8: A second edge of the same kind arriving while an earlier edge of that kind still waits for its partner counts the earlier edge as one error and opens a new window for the second.
- R9: When a window expires in the same cycle that a new edge arrives, the expiry error is counted first and the new edge then opens a fresh window of its own.
- R10: With `win_len` = 0 only edges arriving in the same cycle pair up; one cycle of skew gives an error for each edge. `win_len` is changed only while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high master reset |
| en | input | 1 | Detection enable |
| win_len | input | WIN_W | Tolerance window in sampling-clock cycles |
| ca_in | input | 1 | Primary count input A, asynchronous, idles low |
| cb_in | input | 1 | Companion count input B, asynchronous, idles high |
| err_flag | output | 1 | Sticky flag, high once three errors are counted |
| err_count | output | 2 | Saturating error count |

## Verification
Every cycle, the assertions check that the flag never drops without reset, that the flag agrees with the count at its limit, that the count only moves when the matcher reports an error, that the pending-window timer never runs past the window, and that disabling detection returns the matcher to idle. Whether a given pair of edges is judged good or bad depends on their spacing relative to the window, so the pairing rules (either order, the exact boundary skew, the same-kind supersede rule, the expiry-before-new-edge ordering and the zero-length window) are shown only by the bench's scenarios, which compare the accumulated count and flag after each stimulus.

// File: rtl/pmd_pkg.sv
package pmd_pkg;
  localparam int ERR_LIMIT = 3;
  localparam int CNT_W     = $clog2(ERR_LIMIT + 1);

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_A    = 2'd1,
    PEND_B    = 2'd2
  } pend_e;
endpackage

// File: rtl/pmd_sync.sv
module pmd_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pmd_edge.sv
module pmd_edge (
  input  logic clk,
  input  logic rst,
  input  logic a_lvl,
  input  logic b_lvl,
  output logic a_rise,
  output logic b_fall
);
  logic a_prev, b_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_prev <= 1'b0;
      b_prev <= 1'b1;
    end else begin
      a_prev <= a_lvl;
      b_prev <= b_lvl;
    end
  end

  assign a_rise = a_lvl & ~a_prev;
  assign b_fall = ~b_lvl & b_prev;
endmodule

// File: rtl/pmd_matcher.sv
module pmd_matcher
  import pmd_pkg::*;
#(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIN_W-1:0] win_len,
  input  logic             a_ev,
  input  logic             b_ev,
  output logic             err_o
);
  pend_e            state, state_n, cur;
  logic [WIN_W-1:0] tmr, tmr_n;

  always_comb begin
    state_n = state;
    tmr_n   = tmr;
    err_o   = 1'b0;
    cur     = state;
    if (!en) begin
      state_n = PEND_NONE;
      tmr_n   = '0;
    end else begin
      // expiry is settled before any edge of this cycle is looked at
      if (state != PEND_NONE && tmr >= win_len) begin
        err_o   = 1'b1;
        cur     = PEND_NONE;
        state_n = PEND_NONE;
        tmr_n   = '0;
      end
      unique case (cur)
        PEND_NONE: begin
          if (a_ev && !b_ev) begin
            state_n = PEND_A;
            tmr_n   = '0;
          end else if (b_ev && !a_ev) begin
            state_n = PEND_B;
            tmr_n   = '0;
          end
        end
        PEND_A: begin
          if (b_ev) begin
            state_n = a_ev ? PEND_A : PEND_NONE;
            tmr_n   = '0;
          end else if (a_ev) begin
            err_o   = 1'b1;
            tmr_n   = '0;
          end else begin
            tmr_n   = tmr + 1'b1;
          end
        end
        PEND_B: begin
          if (a_ev) begin
            state_n = b_ev ? PEND_B : PEND_NONE;
            tmr_n   = '0;
          end else if (b_ev) begin
            err_o   = 1'b1;
            tmr_n   = '0;
          end else begin
            tmr_n   = tmr + 1'b1;
          end
        end
        default: state_n = PEND_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PEND_NONE;
      tmr   <= '0;
    end else begin
      state <= state_n;
      tmr   <= tmr_n;
    end
  end

  // R2: an open window never outlives its length
  p_tmr_bounded_r2: assert property (@(posedge clk) disable iff (rst)
    (state != PEND_NONE) |-> (tmr <= win_len));

  // R7: dropping the enable leaves nothing pending
  p_idle_when_off_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> (state == PEND_NONE));
endmodule

// File: rtl/pmd_accum.sv
module pmd_accum
  import pmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic             flag
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ERR_LIMIT);
  logic [CNT_W-1:0] count_n;

  always_comb begin
    count_n = count;
    if (inc && count != LIMIT) count_n = count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      flag  <= 1'b0;
    end else begin
      count <= count_n;
      flag  <= flag | (count_n == LIMIT);
    end
  end

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    flag |=> flag);

  p_flag_at_limit_r4: assert property (@(posedge clk) disable iff (rst)
    (count == LIMIT) |-> flag);

  p_hold_without_err_r5: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(count));

  p_reset_clears_r6: assert property (@(posedge clk)
    rst |=> (count == '0 && !flag));
endmodule

// File: rtl/pulse_mismatch_detector.sv
module pulse_mismatch_detector
  import pmd_pkg::*;
#(
  parameter int WIN_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIN_W-1:0] win_len,
  input  logic             ca_in,
  input  logic             cb_in,
  output logic             err_flag,
  output logic [CNT_W-1:0] err_count
);
  logic a_lvl, b_lvl, a_rise, b_fall, err_pulse;

  pmd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_a (
    .clk(clk), .rst(rst), .d(ca_in), .q(a_lvl));

  pmd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_b (
    .clk(clk), .rst(rst), .d(cb_in), .q(b_lvl));

  pmd_edge u_edge (
    .clk(clk), .rst(rst), .a_lvl(a_lvl), .b_lvl(b_lvl),
    .a_rise(a_rise), .b_fall(b_fall));

  pmd_matcher #(.WIN_W(WIN_W)) u_match (
    .clk(clk), .rst(rst), .en(en), .win_len(win_len),
    .a_ev(a_rise), .b_ev(b_fall), .err_o(err_pulse));

  pmd_accum u_acc (
    .clk(clk), .rst(rst), .inc(err_pulse),
    .count(err_count), .flag(err_flag));

  // R7: with detection off the matcher reports nothing
  p_no_err_when_off_r7: assert property (@(posedge clk) disable iff (rst)
    !en |-> !err_pulse);
endmodule

// File: tb/pulse_mismatch_detector_tb.sv
module pulse_mismatch_detector_tb;
  localparam int WIN_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             en  = 1'b1;
  logic [WIN_W-1:0] win_len = 8'd4;
  logic             ca_in = 1'b0;
  logic             cb_in = 1'b1;
  logic             err_flag;
  logic [1:0]       err_count;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    string tag;
    int    cnt;
    bit    flg;
  } exp_t;
  exp_t q[$];
  exp_t cur_e;

  always #4 clk = ~clk;

  pulse_mismatch_detector #(.WIN_W(WIN_W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .en(en), .win_len(win_len),
    .ca_in(ca_in), .cb_in(cb_in),
    .err_flag(err_flag), .err_count(err_count));

  task automatic push_exp(string tag, int c, bit f);
    exp_t e;
    @(posedge clk);
    #1;
    e.tag = tag;
    e.cnt = c;
    e.flg = f;
    q.push_back(e);
    @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: pops expected items and compares against the outputs.
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        cur_e = q.pop_front();
        n_cmp++;
        if (err_count !== cur_e.cnt[1:0] || err_flag !== cur_e.flg) begin
          n_bad++;
          $display("FAIL %s: count=%0d flag=%0b expected count=%0d flag=%0b",
                   cur_e.tag, err_count, err_flag, cur_e.cnt, cur_e.flg);
        end
      end
    end
  end

  task automatic do_reset(int w);
    @(negedge clk);
    rst = 1'b1;
    win_len = WIN_W'(w);
    ca_in = 1'b0;
    cb_in = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // A pulses start at ta and ta2, B low pulse starts at tb; -1 omits one.
  task automatic stim(int ta, int tb, int ta2, int span);
    for (int c = 0; c < span; c++) begin
      @(negedge clk);
      ca_in = (ta  >= 0 && c >= ta  && c < ta  + 2) ||
              (ta2 >= 0 && c >= ta2 && c < ta2 + 2);
      cb_in = !(tb >= 0 && c >= tb && c < tb + 2);
    end
    @(negedge clk);
    ca_in = 1'b0;
    cb_in = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  initial begin
    do_reset(4);
    push_exp("R6 state after reset", 0, 0);

    stim(2, 2, -1, 12);   push_exp("R1 same-cycle pair", 0, 0);
    stim(2, 5, -1, 12);   push_exp("R1 A leads by 3", 0, 0);
    stim(6, 2, -1, 12);   push_exp("R1 R3 B leads by 4 (boundary)", 0, 0);
    stim(2, 7, -1, 14);   push_exp("R2 skew 5 over window 4", 2, 0);
    stim(2, 4, -1, 12);   push_exp("R5 good pair keeps count", 2, 0);
    stim(2, -1, -1, 8);   push_exp("R2 R4 lone A reaches limit", 3, 1);
    stim(-1, 2, -1, 8);   push_exp("R4 saturates at 3", 3, 1);
    stim(2, 2, -1, 12);   push_exp("R5 flag stays after good pair", 3, 1);

    do_reset(4);
    push_exp("R6 reset clears count and flag", 0, 0);

    @(negedge clk); en = 1'b0;
    stim(2, -1, -1, 8);   push_exp("R7 lone A ignored while disabled", 0, 0);
    stim(-1, 2, -1, 8);   push_exp("R7 lone B ignored while disabled", 0, 0);
    @(negedge clk); en = 1'b1;

    stim(-1, 2, -1, 8);   push_exp("R3 lone B counts one", 1, 0);
    stim(2, -1, 5, 12);   push_exp("R8 repeated A counts two", 3, 1);

    do_reset(4);
    stim(2, 7, 9, 16);    push_exp("R9 expiry then fresh window", 1, 0);
    stim(2, 7, -1, 14);   push_exp("R9 late B opens own window", 3, 1);

    do_reset(0);
    stim(2, 2, -1, 12);   push_exp("R10 zero window same cycle", 0, 0);
    stim(2, 3, -1, 12);   push_exp("R10 zero window skew 1", 2, 0);

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule